// File: doc/BRIEF.md
# Page-Mapped Flash Translation Controller

This block sits between a host that speaks in logical block addresses (LBAs) and a small NAND-style flash array that can only be written into erased pages and only be erased a whole block at a time. A table with one entry per LBA records the physical block and page that holds the current copy of that address. A host read looks up the table and sends a page read to the flash. A host write never overwrites in place. It programs the next free page of the current open block, points the table entry at that page and marks the page it replaces as invalid. Every physical page is free, valid or invalid at all times.

Space comes back through garbage collection. When the number of free pages falls below a threshold, the controller stops taking host commands by holding `h_ready` low. It then picks a victim block, copies each of the victim's still-valid pages into the open block, updates the moved table entries and erases the victim. Each block keeps an erase counter. The counters break ties when a victim is chosen and decide which erased block is opened next, so that wear spreads across the array. The defaults give 8 blocks of 8 pages serving 32 LBAs, and the threshold is two blocks' worth of pages.

The controller is a single state machine. Its states are:
- `ST_IDLE`: waits for a command, or enters collection.
- `ST_RD`: a flash read is in progress.
- `ST_PROG`: a flash program is in progress.
- `ST_RESP`: one-cycle response.
- `ST_GC_PICK`: latches the victim.
- `ST_GC_SCAN`: walks the victim's pages.
- `ST_GC_COPY`: a page relocation is in progress.
- `ST_GC_ERASE`: the victim is being erased.

Its transitions are:
- `ST_IDLE` to `ST_GC_PICK` when collection is needed.
- `ST_IDLE` to `ST_PROG` on a write.
- `ST_IDLE` to `ST_RD` on a read of a mapped LBA.
- `ST_IDLE` to `ST_RESP` on a read of an unmapped LBA.
- `ST_RD` or `ST_PROG` to `ST_RESP` on `f_done`.
- `ST_RESP` to `ST_IDLE`.
- `ST_GC_PICK` to `ST_GC_SCAN`.
- `ST_GC_SCAN` to `ST_GC_COPY` on a valid page.
- `ST_GC_SCAN` or `ST_GC_COPY` to `ST_GC_ERASE` after the last page.
- `ST_GC_COPY` to `ST_GC_SCAN` on `f_done` when pages remain.
- `ST_GC_ERASE` to `ST_IDLE` on `f_done`.

Top module: `ftl_ctrl`

## Requirements
- R1: After reset, `h_ready` is 1, `f_valid` and `rsp_valid` are 0, every page is free, every LBA is unmapped, all erase counters are 0 and block 0 is open with page 0 as the next write target.
- R2: A read of a mapped LBA issues one flash command with `f_op`=0 (read) at the mapped block/page. Its response carries `rsp_unmapped`=0 and that block/page.
- R3: A read of an LBA never written gives a response with `rsp_unmapped`=1 and issues no flash command.
- R4: A write issues `f_op`=1 (program) at the open block's next page. Pages within a block are used in ascending order, and the response carries the programmed block/page.
- R5: A write to an already-mapped LBA goes to a new page. Later reads of that LBA use the new page, and the old page becomes invalid.
- R6: When the open block's last page is programmed, the next open block is the fully free block with the lowest erase count, with a tie going to the lower block index.
- R7: Collection starts when the free-page count is below `GC_LOW`. `h_ready` stays 0 from then until the erase has completed, and `h_ready` is never 1 while free pages are below `GC_LOW`.
- R8: The victim is the block with the most invalid pages, excluding the open block. A tie goes to the lower erase count, then to the lower index.
- R9: Each valid page of the victim is relocated in ascending page order with `f_op`=2 (copy), with source at `f_blk`/`f_pg` and destination at `f_dst_blk`/`f_dst_pg` (the open block's next page). The moved LBA then maps to the destination. A victim with no valid pages gets no copy.
- R10: After relocation, one `f_op`=3 (erase) is issued for the victim. All of its pages return to free and its erase counter increments.
- R11: `f_valid` with its command fields is held stable until `f_done`. Only one flash command is outstanding, and `h_ready` is 0 while it is.
- R12: Each accepted host command yields exactly one `rsp_valid` pulse lasting one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_valid | input | 1 | Host command valid |
| h_ready | output | 1 | Host command accepted when high together with h_valid |
| h_write | input | 1 | 1 = write, 0 = read |
| h_lba | input | clog2(NLBA) | Logical block address |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_unmapped | output | 1 | Read target was never written |
| rsp_blk | output | clog2(NBLK) | Physical block used by the command |
| rsp_pg | output | clog2(NPAGE) | Physical page used by the command |
| f_valid | output | 1 | Flash command valid, held until f_done |
| f_op | output | 2 | 0 read, 1 program, 2 copy, 3 erase |
| f_blk | output | clog2(NBLK) | Target block (copy source) |
| f_pg | output | clog2(NPAGE) | Target page (copy source) |
| f_dst_blk | output | clog2(NBLK) | Copy destination block |
| f_dst_pg | output | clog2(NPAGE) | Copy destination page |
| f_done | input | 1 | Flash command completed |

## Verification
The bench first drives short mixed sequences: fresh writes, reads of mapped and unmapped LBAs, and one rewrite. These separate address lookup from sequential allocation and show the rewrite moving. Two long patterns then fill the array. The first hammers a single LBA, so every victim holds only invalid pages. This exposes the tie-break by index and the choice of the lower-wear erased block over a reused one. The second rewrites selected LBAs so that the block with the most invalid pages still holds one live page, which shows the copy, the remap and the erase order that follow it.

// File: rtl/ftl_pkg.sv
package ftl_pkg;

    typedef enum logic [1:0] {
        PG_FREE    = 2'd0,
        PG_VALID   = 2'd1,
        PG_INVALID = 2'd2
    } pg_e;

    typedef enum logic [1:0] {
        FOP_READ  = 2'd0,
        FOP_PROG  = 2'd1,
        FOP_COPY  = 2'd2,
        FOP_ERASE = 2'd3
    } fop_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_PROG,
        ST_RESP,
        ST_GC_PICK,
        ST_GC_SCAN,
        ST_GC_COPY,
        ST_GC_ERASE
    } fsm_e;

endpackage

// File: rtl/ftl_victim_sel.sv
// Picks the collection victim: most invalid pages, then fewest erases,
// then lowest index; the open block is never eligible.
module ftl_victim_sel #(
    parameter int NBLK = 8,
    parameter int CW   = 4,
    parameter int ECW  = 16,
    localparam int BW  = $clog2(NBLK)
) (
    input  logic [NBLK*CW-1:0]  inv_cnt,
    input  logic [NBLK*ECW-1:0] ers_cnt,
    input  logic [BW-1:0]       open_blk,
    output logic                found,
    output logic [BW-1:0]       victim
);
    logic [CW-1:0]  best_inv;
    logic [ECW-1:0] best_ec;

    always_comb begin
        found    = 1'b0;
        victim   = '0;
        best_inv = '0;
        best_ec  = '0;
        for (int b = 0; b < NBLK; b++) begin
            if (BW'(b) != open_blk && inv_cnt[b*CW +: CW] != '0) begin
                if (!found
                    || inv_cnt[b*CW +: CW] > best_inv
                    || (inv_cnt[b*CW +: CW] == best_inv
                        && ers_cnt[b*ECW +: ECW] < best_ec)) begin
                    found    = 1'b1;
                    victim   = BW'(b);
                    best_inv = inv_cnt[b*CW +: CW];
                    best_ec  = ers_cnt[b*ECW +: ECW];
                end
            end
        end
    end
endmodule

// File: rtl/ftl_alloc_sel.sv
// Chooses the next open block among fully erased blocks by lowest wear.
module ftl_alloc_sel #(
    parameter int NBLK  = 8,
    parameter int NPAGE = 8,
    parameter int CW    = 4,
    parameter int ECW   = 16,
    localparam int BW   = $clog2(NBLK)
) (
    input  logic [NBLK*CW-1:0]  free_cnt,
    input  logic [NBLK*ECW-1:0] ers_cnt,
    output logic [BW-1:0]       next_blk
);
    logic           seen;
    logic [ECW-1:0] best_ec;

    always_comb begin
        seen     = 1'b0;
        next_blk = '0;
        best_ec  = '0;
        for (int b = 0; b < NBLK; b++) begin
            if (free_cnt[b*CW +: CW] == CW'(NPAGE)) begin
                if (!seen || ers_cnt[b*ECW +: ECW] < best_ec) begin
                    seen     = 1'b1;
                    next_blk = BW'(b);
                    best_ec  = ers_cnt[b*ECW +: ECW];
                end
            end
        end
    end
endmodule

// File: rtl/ftl_ctrl.sv
// Page-mapped translation controller. NBLK and NPAGE must be powers of two.
module ftl_ctrl
    import ftl_pkg::*;
#(
    parameter int NBLK   = 8,
    parameter int NPAGE  = 8,
    parameter int NLBA   = 32,
    parameter int ECW    = 16,
    parameter int GC_LOW = 2 * NPAGE
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      h_valid,
    output logic                      h_ready,
    input  logic                      h_write,
    input  logic [$clog2(NLBA)-1:0]   h_lba,
    output logic                      rsp_valid,
    output logic                      rsp_unmapped,
    output logic [$clog2(NBLK)-1:0]   rsp_blk,
    output logic [$clog2(NPAGE)-1:0]  rsp_pg,
    output logic                      f_valid,
    output logic [1:0]                f_op,
    output logic [$clog2(NBLK)-1:0]   f_blk,
    output logic [$clog2(NPAGE)-1:0]  f_pg,
    output logic [$clog2(NBLK)-1:0]   f_dst_blk,
    output logic [$clog2(NPAGE)-1:0]  f_dst_pg,
    input  logic                      f_done
);
    localparam int BW  = $clog2(NBLK);
    localparam int PW  = $clog2(NPAGE);
    localparam int LW  = $clog2(NLBA);
    localparam int IW  = BW + PW;
    localparam int NPG = NBLK * NPAGE;
    localparam int CW  = $clog2(NPAGE + 1);
    localparam int TW  = $clog2(NPG + 1);

    fsm_e state_q, state_d;

    pg_e             pst       [NPG];
    logic [LW-1:0]   owner     [NPG];
    logic [IW-1:0]   map_loc   [NLBA];
    logic [NLBA-1:0] map_vld;
    logic [ECW-1:0]  erase_cnt [NBLK];

    logic [BW-1:0] open_blk, open_nx, alloc_blk, victim_c, victim_q;
    logic [PW-1:0] wptr, wptr_nx, scan;
    logic          victim_ok, gc_need, accept, scan_last;
    logic [LW-1:0] cmd_lba, mv_lba;
    logic          resp_unm;
    logic [IW-1:0] resp_loc, wr_loc, src_loc;

    logic [NBLK*CW-1:0]  inv_flat, free_flat;
    logic [NBLK*ECW-1:0] ec_flat;
    logic [TW-1:0]       free_total;

    // per-block page-state census
    for (genvar gb = 0; gb < NBLK; gb++) begin : g_blk
        logic [CW-1:0] n_inv, n_free;
        always_comb begin
            n_inv  = '0;
            n_free = '0;
            for (int p = 0; p < NPAGE; p++) begin
                if (pst[IW'(gb * NPAGE + p)] == PG_INVALID) n_inv  = n_inv + CW'(1);
                if (pst[IW'(gb * NPAGE + p)] == PG_FREE)    n_free = n_free + CW'(1);
            end
        end
        assign inv_flat[gb*CW +: CW]    = n_inv;
        assign free_flat[gb*CW +: CW]   = n_free;
        assign ec_flat[gb*ECW +: ECW]   = erase_cnt[gb];
    end

    always_comb begin
        free_total = '0;
        for (int b = 0; b < NBLK; b++) free_total = free_total + TW'(free_flat[b*CW +: CW]);
    end

    ftl_victim_sel #(.NBLK(NBLK), .CW(CW), .ECW(ECW)) u_victim (
        .inv_cnt (inv_flat),
        .ers_cnt (ec_flat),
        .open_blk(open_blk),
        .found   (victim_ok),
        .victim  (victim_c)
    );

    ftl_alloc_sel #(.NBLK(NBLK), .NPAGE(NPAGE), .CW(CW), .ECW(ECW)) u_alloc (
        .free_cnt(free_flat),
        .ers_cnt (ec_flat),
        .next_blk(alloc_blk)
    );

    assign gc_need   = (free_total < TW'(GC_LOW)) && victim_ok;
    assign wr_loc    = {open_blk, wptr};
    assign src_loc   = {victim_q, scan};
    assign scan_last = (scan == PW'(NPAGE - 1));
    assign mv_lba    = owner[src_loc];
    assign accept    = h_valid && h_ready;

    // write-pointer advance, opening a new block after the last page
    always_comb begin
        if (wptr == PW'(NPAGE - 1)) begin
            open_nx = alloc_blk;
            wptr_nx = '0;
        end else begin
            open_nx = open_blk;
            wptr_nx = wptr + PW'(1);
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (gc_need)                state_d = ST_GC_PICK;
                else if (h_valid && h_write) state_d = ST_PROG;
                else if (h_valid)           state_d = map_vld[h_lba] ? ST_RD : ST_RESP;
            end
            ST_RD:       if (f_done) state_d = ST_RESP;
            ST_PROG:     if (f_done) state_d = ST_RESP;
            ST_RESP:     state_d = ST_IDLE;
            ST_GC_PICK:  state_d = ST_GC_SCAN;
            ST_GC_SCAN: begin
                if (pst[src_loc] == PG_VALID) state_d = ST_GC_COPY;
                else if (scan_last)           state_d = ST_GC_ERASE;
            end
            ST_GC_COPY:  if (f_done) state_d = scan_last ? ST_GC_ERASE : ST_GC_SCAN;
            ST_GC_ERASE: if (f_done) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        h_ready      = 1'b0;
        rsp_valid    = 1'b0;
        rsp_unmapped = resp_unm;
        rsp_blk      = resp_loc[IW-1:PW];
        rsp_pg       = resp_loc[PW-1:0];
        f_valid      = 1'b0;
        f_op         = FOP_READ;
        f_blk        = '0;
        f_pg         = '0;
        f_dst_blk    = '0;
        f_dst_pg     = '0;
        unique case (state_q)
            ST_IDLE: h_ready = !gc_need;
            ST_RD: begin
                f_valid = 1'b1;
                f_op    = FOP_READ;
                f_blk   = map_loc[cmd_lba][IW-1:PW];
                f_pg    = map_loc[cmd_lba][PW-1:0];
            end
            ST_PROG: begin
                f_valid = 1'b1;
                f_op    = FOP_PROG;
                f_blk   = open_blk;
                f_pg    = wptr;
            end
            ST_RESP: rsp_valid = 1'b1;
            ST_GC_PICK, ST_GC_SCAN: ;
            ST_GC_COPY: begin
                f_valid   = 1'b1;
                f_op      = FOP_COPY;
                f_blk     = victim_q;
                f_pg      = scan;
                f_dst_blk = open_blk;
                f_dst_pg  = wptr;
            end
            ST_GC_ERASE: begin
                f_valid = 1'b1;
                f_op    = FOP_ERASE;
                f_blk   = victim_q;
            end
            default: ;
        endcase
    end

    // tables and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NPG; i++) begin
                pst[i]   <= PG_FREE;
                owner[i] <= '0;
            end
            for (int l = 0; l < NLBA; l++) map_loc[l] <= '0;
            for (int b = 0; b < NBLK; b++) erase_cnt[b] <= '0;
            map_vld  <= '0;
            open_blk <= '0;
            wptr     <= '0;
            victim_q <= '0;
            scan     <= '0;
            cmd_lba  <= '0;
            resp_unm <= 1'b0;
            resp_loc <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        cmd_lba  <= h_lba;
                        resp_unm <= !h_write && !map_vld[h_lba];
                        resp_loc <= (!h_write && map_vld[h_lba]) ? map_loc[h_lba] : '0;
                    end
                end
                ST_PROG: begin
                    if (f_done) begin
                        if (map_vld[cmd_lba]) pst[map_loc[cmd_lba]] <= PG_INVALID;
                        pst[wr_loc]       <= PG_VALID;
                        owner[wr_loc]     <= cmd_lba;
                        map_loc[cmd_lba]  <= wr_loc;
                        map_vld[cmd_lba]  <= 1'b1;
                        resp_loc          <= wr_loc;
                        open_blk          <= open_nx;
                        wptr              <= wptr_nx;
                    end
                end
                ST_GC_PICK: begin
                    victim_q <= victim_c;
                    scan     <= '0;
                end
                ST_GC_SCAN: begin
                    if (pst[src_loc] != PG_VALID && !scan_last) scan <= scan + PW'(1);
                end
                ST_GC_COPY: begin
                    if (f_done) begin
                        pst[src_loc]    <= PG_INVALID;
                        pst[wr_loc]     <= PG_VALID;
                        owner[wr_loc]   <= mv_lba;
                        map_loc[mv_lba] <= wr_loc;
                        open_blk        <= open_nx;
                        wptr            <= wptr_nx;
                        if (!scan_last) scan <= scan + PW'(1);
                    end
                end
                ST_GC_ERASE: begin
                    if (f_done) begin
                        for (int p = 0; p < NPAGE; p++) pst[{victim_q, PW'(p)}] <= PG_FREE;
                        if (erase_cnt[victim_q] != '1)
                            erase_cnt[victim_q] <= erase_cnt[victim_q] + ECW'(1);
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ftl_ctrl_chk.sv
module ftl_ctrl_chk #(
    parameter int BW     = 3,
    parameter int TW     = 7,
    parameter int GC_LOW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          h_ready,
    input logic          rsp_valid,
    input logic          rsp_unmapped,
    input logic          f_valid,
    input logic [1:0]    f_op,
    input logic [BW-1:0] f_blk,
    input logic          f_done,
    input logic [BW-1:0] open_blk,
    input logic [TW-1:0] free_total
);
    AST_FLASH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        f_valid && !f_done |=> f_valid && $stable(f_op) && $stable(f_blk)); // R11

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        f_valid |-> !h_ready); // R11

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R12

    AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_unmapped |-> !f_valid && !$past(f_valid)); // R3

    AST_LOW_FREE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        h_ready |-> free_total >= TW'(GC_LOW)); // R7

    AST_ERASE_NOT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        f_valid && f_op == 2'd3 |-> f_blk != open_blk); // R8
endmodule

bind ftl_ctrl ftl_ctrl_chk #(
    .BW    ($clog2(NBLK)),
    .TW    ($clog2(NBLK*NPAGE+1)),
    .GC_LOW(GC_LOW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .h_ready     (h_ready),
    .rsp_valid   (rsp_valid),
    .rsp_unmapped(rsp_unmapped),
    .f_valid     (f_valid),
    .f_op        (f_op),
    .f_blk       (f_blk),
    .f_done      (f_done),
    .open_blk    (open_blk),
    .free_total  (free_total)
);

// File: tb/sim_ftl_ctrl.sv
`timescale 1ns/1ps
module sim_ftl_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       h_valid, h_write, h_ready;
    logic [4:0] h_lba;
    logic       rsp_valid, rsp_unmapped;
    logic [2:0] rsp_blk, rsp_pg;
    logic       f_valid, f_done;
    logic [1:0] f_op;
    logic [2:0] f_blk, f_pg, f_dst_blk, f_dst_pg;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    ftl_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .h_valid(h_valid), .h_ready(h_ready), .h_write(h_write), .h_lba(h_lba),
        .rsp_valid(rsp_valid), .rsp_unmapped(rsp_unmapped), .rsp_blk(rsp_blk), .rsp_pg(rsp_pg),
        .f_valid(f_valid), .f_op(f_op), .f_blk(f_blk), .f_pg(f_pg),
        .f_dst_blk(f_dst_blk), .f_dst_pg(f_dst_pg), .f_done(f_done)
    );

    // flash model: log each command, answer with done after one wait cycle
    int         lg_n = 0;
    logic [1:0] lg_op   [256];
    logic [2:0] lg_blk  [256];
    logic [2:0] lg_pg   [256];
    logic [2:0] lg_dblk [256];
    logic [2:0] lg_dpg  [256];
    int         busy = 0;

    initial begin
        f_done = 1'b0;
        forever begin
            @(negedge clk);
            if (f_done) f_done = 1'b0;
            else if (f_valid) begin
                if (busy == 0) begin
                    if (lg_n < 256) begin
                        lg_op[lg_n]   = f_op;
                        lg_blk[lg_n]  = f_blk;
                        lg_pg[lg_n]   = f_pg;
                        lg_dblk[lg_n] = f_dst_blk;
                        lg_dpg[lg_n]  = f_dst_pg;
                        lg_n++;
                    end
                    busy = 1;
                end else begin
                    f_done = 1'b1;
                    busy   = 0;
                end
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    logic       r_unm, r_after, r_pulse;
    logic [2:0] r_blk, r_pg;

    task automatic do_cmd(input logic wr, input int lba);
        @(negedge clk);
        while (!h_ready) @(negedge clk);
        h_valid = 1'b1;
        h_write = wr;
        h_lba   = 5'(lba);
        @(negedge clk);
        h_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        r_unm = rsp_unmapped;
        r_blk = rsp_blk;
        r_pg  = rsp_pg;
        @(negedge clk);
        r_pulse = rsp_valid;
        r_after = h_ready;
    endtask

    task automatic do_reset();
        h_valid = 1'b0;
        h_write = 1'b0;
        h_lba   = '0;
        rst_n   = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // {write, lba[4:0], unmapped, blk[2:0], pg[2:0]}
    localparam logic [12:0] VEC [14] = '{
        {1'b1, 5'd0,  1'b0, 3'd0, 3'd0},
        {1'b1, 5'd1,  1'b0, 3'd0, 3'd1},
        {1'b1, 5'd2,  1'b0, 3'd0, 3'd2},
        {1'b1, 5'd3,  1'b0, 3'd0, 3'd3},
        {1'b1, 5'd4,  1'b0, 3'd0, 3'd4},
        {1'b1, 5'd5,  1'b0, 3'd0, 3'd5},
        {1'b1, 5'd6,  1'b0, 3'd0, 3'd6},
        {1'b1, 5'd7,  1'b0, 3'd0, 3'd7},
        {1'b1, 5'd8,  1'b0, 3'd1, 3'd0},   // R6: block 1 opened
        {1'b0, 5'd3,  1'b0, 3'd0, 3'd3},
        {1'b0, 5'd20, 1'b1, 3'd0, 3'd0},
        {1'b1, 5'd3,  1'b0, 3'd1, 3'd1},   // R5: rewrite moves
        {1'b0, 5'd3,  1'b0, 3'd1, 3'd1},   // R5: read follows new page
        {1'b0, 5'd8,  1'b0, 3'd1, 3'd0}
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 h_ready", h_ready, 1);
        chk("R1 f_valid", f_valid, 0);
        chk("R1 rsp_valid", rsp_valid, 0);

        for (int i = 0; i < 14; i++) begin
            logic [12:0] v;
            int          ln;
            string       tag;
            v  = VEC[i];
            ln = lg_n;
            tag = v[6] ? "R3" : (v[12] ? "R4" : "R2");
            do_cmd(v[12], int'(v[11:7]));
            chk({tag, " unmapped"}, r_unm, v[6]);
            chk({tag, " blk"}, r_blk, v[5:3]);
            chk({tag, " pg"}, r_pg, v[2:0]);
            chk("R12 pulse", r_pulse, 0);
            if (v[6]) chk("R3 no flash op", lg_n - ln, 0);
            else begin
                chk({tag, " op count"}, lg_n - ln, 1);
                chk("R11 op code", lg_op[ln], v[12] ? 1 : 0);
                chk({tag, " flash blk"}, lg_blk[ln], v[5:3]);
                chk({tag, " flash pg"}, lg_pg[ln], v[2:0]);
            end
        end

        // Scenario A: hammer one LBA, victims hold only invalid pages
        do_reset();
        for (int i = 0; i < 8; i++) do_cmd(1'b1, i);
        for (int i = 8; i < 49; i++) begin
            do_cmd(1'b1, 0);
            if (i == 47) begin
                chk("R7 no early stall", r_after, 1);
                chk("R4 blk", r_blk, 5);
                chk("R4 pg", r_pg, 7);
            end
        end
        chk("R6 blk", r_blk, 6);
        chk("R6 pg", r_pg, 0);
        chk("R7 stall", r_after, 0);
        begin
            int ln;
            ln = lg_n;
            do_cmd(1'b1, 0);
            chk("R9 no copy", lg_n - ln, 2);
            chk("R10 erase op", lg_op[ln], 3);
            chk("R8 victim by index", lg_blk[ln], 1);
            chk("R4 prog op", lg_op[ln+1], 1);
            chk("R4 after gc blk", r_blk, 6);
            chk("R4 after gc pg", r_pg, 1);
        end
        for (int i = 0; i < 6; i++) do_cmd(1'b1, 0);
        do_cmd(1'b1, 0);
        chk("R6 wear pick blk", r_blk, 7);
        chk("R6 wear pick pg", r_pg, 0);
        chk("R7 stall again", r_after, 0);
        begin
            int ln;
            ln = lg_n;
            do_cmd(1'b1, 0);
            chk("R8 second victim", lg_blk[ln], 2);
            chk("R10 second erase", lg_op[ln], 3);
            chk("R4 pg", r_pg, 1);
        end

        // Scenario B: victim keeps one live page
        do_reset();
        for (int i = 0; i < 32; i++) do_cmd(1'b1, i);
        for (int i = 0; i < 5; i++)  do_cmd(1'b1, i);
        for (int i = 8; i < 12; i++) do_cmd(1'b1, i);
        for (int i = 0; i < 8; i++)  do_cmd(1'b1, 31);
        chk("R4 blk", r_blk, 6);
        chk("R7 stall", r_after, 0);
        begin
            int ln;
            ln = lg_n;
            do_cmd(1'b1, 20);
            chk("R9 op count", lg_n - ln, 3);
            chk("R9 copy op", lg_op[ln], 2);
            chk("R8 victim most invalid", lg_blk[ln], 5);
            chk("R9 src pg", lg_pg[ln], 0);
            chk("R9 dst blk", lg_dblk[ln], 6);
            chk("R9 dst pg", lg_dpg[ln], 1);
            chk("R10 erase after copy", lg_op[ln+1], 3);
            chk("R10 erase blk", lg_blk[ln+1], 5);
            chk("R4 pg after copy", r_pg, 2);
        end
        begin
            int ln;
            ln = lg_n;
            do_cmd(1'b0, 11);
            chk("R9 remap blk", r_blk, 6);
            chk("R9 remap pg", r_pg, 1);
            chk("R2 read op at remap", lg_blk[ln] * 8 + lg_pg[ln], 49);
        end
        do_cmd(1'b0, 4);
        chk("R5 moved blk", r_blk, 4);
        chk("R5 moved pg", r_pg, 4);
        do_cmd(1'b0, 31);
        chk("R5 latest copy", r_blk * 8 + r_pg, 48);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule